// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Multistage Switch

This block is a blocking multistage interconnect that links P source ports to P destination ports. The fabric has log2(P) columns of two-by-two switching elements, P/2 elements per column, and a perfect-shuffle permutation of the lines in front of every column. Each source port offers a request made of a valid bit, a destination index and a data word.

In routing mode, every element sets itself from one bit of each request's destination. When two requests inside the fabric need the same element output, one of them is discarded, and its source learns this in the same cycle. In fixed mode, each element holds a position that was loaded earlier through a small write port, and the destination fields are not used.

Deliveries are registered. Each destination port shows a valid bit, the data word and the index of the source it came from, one clock after the requests were presented.

Top module: `omega_net`

## Requirements
- R1: After reset, every `out_valid` bit is 0, and every element of the fixed-mode configuration is straight (0).
- R2: In routing mode, a request from source s to destination d that is not discarded appears one clock later on output port d, with `out_valid[d]`=1 and `out_data` equal to the source's data word.
- R3: In routing mode, column k (k=0 nearest the sources) steers on destination bit log2(P)-1-k. A bit value of 0 selects the element's upper output (even line) and a value of 1 selects its lower output (odd line). Before every column, line i moves to line rotate-left-by-one(i). With these rules, the identity permutation (d=s for every source) is delivered with no discards.
- R4: When both inputs of an element want the same output, the request on the upper (even) input line wins. With P=8, the requests 2→6 and 6→4 collide in column 0, so 2→6 is delivered and 6→4 is discarded.
- R5: `req_blocked[s]` is combinational. It is 1 in the same cycle exactly when source s has a valid request that was discarded. A discarded request produces no output.
- R6: In fixed mode, each element passes its upper input to its upper output when its stored bit is 0, and crosses the two inputs when the bit is 1. `req_blocked` is always 0 in this mode, and the destination fields have no effect. With every bit at 0, source i reaches output i.
- R7: A write with `cfg_we`=1 stores `cfg_cross` into the element selected by `cfg_stage` (column) and `cfg_switch` (element within the column). The new value applies from the next cycle. `static_mode` changes only in cycles with no valid request.
- R8: In a cycle with no valid requests, no output is valid on the next cycle and no source is flagged as blocked.
- R9: `out_src` of each delivered port holds the index of the source the word came from, and the field positions of every port are aligned with its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| static_mode | input | 1 | 1 = fixed positions, 0 = routing on destination bits |
| cfg_we | input | 1 | Write strobe for one element position |
| cfg_stage | input | STW | Column index of the write |
| cfg_switch | input | SWW | Element index within the column |
| cfg_cross | input | 1 | Position to store: 0 straight, 1 crossed |
| req_valid | input | P | Request present, one bit per source |
| req_dest | input | P*LW | Destination index per source, source s at bits [s*LW +: LW] |
| req_data | input | P*DW | Data word per source, source s at bits [s*DW +: DW] |
| req_blocked | output | P | Request discarded this cycle, one bit per source |
| out_valid | output | P | Registered delivery flag per destination |
| out_data | output | P*DW | Registered data word per destination |
| out_src | output | P*LW | Registered source index per destination |

## Verification
The hardest case to reach from the ports is a discard deep in the fabric. Two requests that leave column 0 cleanly still have to meet on the same element in a later column and want the same output. The bench reaches such meetings with the bit-reversal permutation and with many random request sets in which several sources aim at nearby destinations. Each of these sets is compared against a separate stage-by-stage walk of positions. The named 2→6 / 6→4 pair fixes the priority rule, and a fully crossed fixed configuration drives every element to its non-default position.

// File: rtl/omega_net.sv
module omega_net #(
  parameter int P  = 8,
  parameter int DW = 8,
  localparam int LW   = $clog2(P),
  localparam int HALF = P / 2,
  localparam int SWW  = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int STW  = (LW > 1) ? $clog2(LW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            static_mode,
  input  logic            cfg_we,
  input  logic [STW-1:0]  cfg_stage,
  input  logic [SWW-1:0]  cfg_switch,
  input  logic            cfg_cross,
  input  logic [P-1:0]    req_valid,
  input  logic [P*LW-1:0] req_dest,
  input  logic [P*DW-1:0] req_data,
  output logic [P-1:0]    req_blocked,
  output logic [P-1:0]    out_valid,
  output logic [P*DW-1:0] out_data,
  output logic [P*LW-1:0] out_src
);

  logic            lv [0:LW][0:P-1];
  logic [LW-1:0]   ld [0:LW][0:P-1];
  logic [DW-1:0]   lx [0:LW][0:P-1];
  logic [LW-1:0]   ls [0:LW][0:P-1];
  logic [HALF-1:0] cfg_q [0:LW-1];
  logic [P-1:0]    blk;

  int   ui, li, tu, tl;
  logic ub, lb, drop;

  function automatic int rotr(input int j);
    return (j >> 1) | ((j & 1) << (LW - 1));
  endfunction

  always_comb begin
    blk = '0;
    ui = 0; li = 0; tu = 0; tl = 0; ub = 1'b0; lb = 1'b0; drop = 1'b0;
    for (int i = 0; i < P; i++) begin
      lv[0][i] = req_valid[i];
      ld[0][i] = req_dest[i*LW +: LW];
      lx[0][i] = req_data[i*DW +: DW];
      ls[0][i] = LW'(i);
    end
    for (int k = 0; k < LW; k++) begin
      for (int i = 0; i < P; i++) begin
        lv[k+1][i] = 1'b0;
        ld[k+1][i] = '0;
        lx[k+1][i] = '0;
        ls[k+1][i] = '0;
      end
      for (int w = 0; w < HALF; w++) begin
        ui = rotr(2*w);
        li = rotr(2*w + 1);
        ub = ld[k][ui][LW-1-k];
        lb = ld[k][li][LW-1-k];
        if (static_mode) begin
          tu = cfg_q[k][w] ? 1 : 0;
          tl = cfg_q[k][w] ? 0 : 1;
        end else begin
          tu = ub ? 1 : 0;
          tl = lb ? 1 : 0;
        end
        drop = !static_mode && lv[k][ui] && lv[k][li] && (ub == lb);
        if (static_mode || lv[k][ui]) begin
          lv[k+1][2*w+tu] = lv[k][ui];
          ld[k+1][2*w+tu] = ld[k][ui];
          lx[k+1][2*w+tu] = lx[k][ui];
          ls[k+1][2*w+tu] = ls[k][ui];
        end
        if ((static_mode || lv[k][li]) && !drop) begin
          lv[k+1][2*w+tl] = lv[k][li];
          ld[k+1][2*w+tl] = ld[k][li];
          lx[k+1][2*w+tl] = lx[k][li];
          ls[k+1][2*w+tl] = ls[k][li];
        end
        if (drop) blk[ls[k][li]] = 1'b1;
      end
    end
  end

  assign req_blocked = blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < LW; k++) cfg_q[k] <= '0;
    end else if (cfg_we && (32'(cfg_stage) < LW)) begin
      cfg_q[cfg_stage][cfg_switch] <= cfg_cross;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= '0;
      out_data  <= '0;
      out_src   <= '0;
    end else begin
      for (int i = 0; i < P; i++) begin
        out_valid[i]         <= lv[LW][i];
        out_data[i*DW +: DW] <= lx[LW][i];
        out_src[i*LW +: LW]  <= ls[LW][i];
      end
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> out_valid == '0); // R1
  AST_DELIVER_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $countones(out_valid) == $past($countones(req_valid & ~req_blocked))); // R2
  AST_BLOCK_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    (req_blocked & ~req_valid) == '0); // R5
  AST_FIXED_NO_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    static_mode |-> req_blocked == '0); // R6
  AST_MODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(static_mode) |-> req_valid == '0); // R7
  AST_IDLE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid == '0 |=> out_valid == '0); // R8

endmodule

// File: tb/omega_net_tb.sv
module omega_net_tb_top;
  localparam int P = 8, DW = 8, LW = 3, HALF = 4, SWW = 2, STW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic static_mode = 1'b0, cfg_we = 1'b0, cfg_cross = 1'b0;
  logic [STW-1:0] cfg_stage = '0;
  logic [SWW-1:0] cfg_switch = '0;
  logic [P-1:0] req_valid = '0;
  logic [P*LW-1:0] req_dest = '0;
  logic [P*DW-1:0] req_data = '0;
  logic [P-1:0] req_blocked, out_valid;
  logic [P*DW-1:0] out_data;
  logic [P*LW-1:0] out_src;

  int total = 0, bad = 0;
  bit finished = 0;
  bit cfgm [LW][HALF];
  logic [P-1:0] ev, eb;
  int esrc [P];
  int salt = 0;

  always #5 clk = ~clk;

  omega_net #(.P(P), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .static_mode(static_mode), .cfg_we(cfg_we),
    .cfg_stage(cfg_stage), .cfg_switch(cfg_switch), .cfg_cross(cfg_cross),
    .req_valid(req_valid), .req_dest(req_dest), .req_data(req_data),
    .req_blocked(req_blocked), .out_valid(out_valid), .out_data(out_data), .out_src(out_src));

  function automatic logic [DW-1:0] word_of(int s, int sl);
    return DW'(s * 37 + sl * 11 + 5);
  endfunction

  function automatic int rotl(int x);
    return ((x << 1) | (x >> (LW-1))) & (P-1);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // walks every request column by column on positions
  task automatic model(input bit st, input logic [P-1:0] vin, input int dst [P]);
    int pos [P];
    int want [P];
    bit alive [P];
    for (int i = 0; i < P; i++) begin pos[i] = i; alive[i] = vin[i]; end
    eb = '0;
    for (int k = 0; k < LW; k++) begin
      for (int i = 0; i < P; i++) begin
        pos[i] = rotl(pos[i]);
        if (st) want[i] = (pos[i] & ~1) | ((pos[i] & 1) ^ int'(cfgm[k][pos[i] >> 1]));
        else    want[i] = (pos[i] & ~1) | ((dst[i] >> (LW-1-k)) & 1);
      end
      for (int i = 0; i < P; i++)
        for (int j = 0; j < P; j++)
          if (!st && i != j && alive[i] && alive[j] && want[i] == want[j] && (pos[i] & 1) == 1)
            eb[i] = 1'b1;
      for (int i = 0; i < P; i++) begin
        if (eb[i]) alive[i] = 0;
        pos[i] = want[i];
      end
    end
    ev = '0;
    for (int i = 0; i < P; i++) esrc[i] = 0;
    for (int i = 0; i < P; i++)
      if (alive[i]) begin ev[pos[i]] = 1'b1; esrc[pos[i]] = i; end
  endtask

  task automatic apply(string req, logic [P-1:0] vin, input int dst [P]);
    @(negedge clk);
    salt++;
    req_valid = vin;
    for (int i = 0; i < P; i++) begin
      req_dest[i*LW +: LW] = LW'(dst[i]);
      req_data[i*DW +: DW] = word_of(i, salt);
    end
    model(static_mode, vin, dst);
    #1;
    check({req, " R5 blocked"}, 64'(req_blocked), 64'(eb));
    @(posedge clk); #1;
    req_valid = '0;
    check({req, " R2 out_valid"}, 64'(out_valid), 64'(ev));
    for (int o = 0; o < P; o++)
      if (ev[o]) begin
        check({req, " R2 out_data"}, 64'(out_data[o*DW +: DW]), 64'(word_of(esrc[o], salt)));
        check({req, " R9 out_src"}, 64'(out_src[o*LW +: LW]), 64'(esrc[o]));
      end
  endtask

  task automatic set_mode(bit m);
    @(negedge clk);
    req_valid = '0;
    static_mode = m;
    @(negedge clk);
  endtask

  task automatic cfg_write(int st, int sw, bit pos);
    @(negedge clk);
    cfg_we = 1'b1; cfg_stage = STW'(st); cfg_switch = SWW'(sw); cfg_cross = pos;
    @(negedge clk);
    cfg_we = 1'b0;
    cfgm[st][sw] = pos;
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", 64'(out_valid), 64'h0);
    check("R8 blocked idle", 64'(req_blocked), 64'h0);
  endtask

  task automatic t_identity();
    int d [P];
    for (int i = 0; i < P; i++) d[i] = i;
    apply("R3 identity", '1, d);
    check("R3 identity no discards", 64'(eb), 64'h0);
  endtask

  task automatic t_bitrev();
    int d [P];
    for (int i = 0; i < P; i++) d[i] = ((i & 1) << 2) | (i & 2) | ((i >> 2) & 1);
    apply("R3 bit-reversal", '1, d);
  endtask

  task automatic t_conflict();
    int d [P];
    for (int i = 0; i < P; i++) d[i] = 0;
    d[2] = 6; d[6] = 4;
    @(negedge clk);
    salt++;
    req_valid = 8'b0100_0100;
    for (int i = 0; i < P; i++) begin
      req_dest[i*LW +: LW] = LW'(d[i]);
      req_data[i*DW +: DW] = word_of(i, salt);
    end
    #1;
    check("R4 conflict blocked", 64'(req_blocked), 64'h40);
    @(posedge clk); #1;
    req_valid = '0;
    check("R4 conflict out_valid", 64'(out_valid), 64'h40);
    check("R4 winner data", 64'(out_data[6*DW +: DW]), 64'(word_of(2, salt)));
    check("R9 winner src", 64'(out_src[6*LW +: LW]), 64'd2);
  endtask

  task automatic t_idle();
    int d [P];
    for (int i = 0; i < P; i++) d[i] = 7 - i;
    apply("R8 idle", '0, d);
    check("R8 idle outputs", 64'(out_valid), 64'h0);
  endtask

  task automatic t_random(int n);
    int d [P];
    for (int r = 0; r < n; r++) begin
      for (int i = 0; i < P; i++) d[i] = int'($urandom_range(P-1, 0));
      apply("R5 random", P'($urandom), d);
    end
  endtask

  task automatic t_static();
    int d [P];
    set_mode(1'b1);
    for (int i = 0; i < P; i++) d[i] = int'($urandom_range(P-1, 0));
    apply("R6 fixed default", '1, d);
    for (int i = 0; i < P; i++)
      check("R6 straight maps i to i", 64'(out_src[i*LW +: LW]), 64'(i));
    for (int k = 0; k < LW; k++)
      for (int w = 0; w < HALF; w++) cfg_write(k, w, 1'b1);
    apply("R7 fixed all crossed", '1, d);
    for (int i = 0; i < P; i++) d[i] = P - 1 - i;
    apply("R6 dest ignored", 8'b1010_0110, d);
    cfg_write(1, 2, 1'b0);
    cfg_write(0, 0, 1'b0);
    apply("R7 fixed mixed", '1, d);
    set_mode(1'b0);
    for (int i = 0; i < P; i++) d[i] = i;
    apply("R6 back to routing", '1, d);
  endtask

  initial begin
    for (int k = 0; k < LW; k++)
      for (int w = 0; w < HALF; w++) cfgm[k][w] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_identity();
    t_bitrev();
    t_conflict();
    t_idle();
    t_random(60);
    t_static();
    t_random(20);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule